// File: doc/BRIEF.md
# I2C Bus Monitor with 10-bit Address Recovery

This block watches the clock and data lines of an I2C bus without ever driving them. Both lines are brought into the system clock domain through synchronizer flops. Line edges are found on the synchronized copies. From those edges the block recognises bus conditions and assembles the serial bits into bytes. Each transaction is reported as a stream of single-cycle events: a start, a repeated start, a stop, a completed byte with its class, and the acknowledge slot that follows each byte.

Address bytes are decoded as they arrive. A first address byte whose upper five bits are 11110 opens a 10-bit address. The monitor then stays in the address phase for exactly one more byte and combines the two bytes into a 10-bit target address. Any other first byte carries a 7-bit address. The transfer direction comes from the first address byte alone. A configuration input chooses whether a 7-bit address byte is reported with or without its direction bit.

The block is meant to sit beside an I2C controller or target as a protocol tracer. A downstream logger or checker can consume its events. Clock stretching needs no special handling, because every step is driven by line edges rather than by a bit timer.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After reset, and until the first start condition, `evt_valid` stays low.
- R2: A falling SDA while SCL is high produces one event. Its code is 0 (start) when no transfer is open and 1 (repeated start) when a start has been seen with no stop since. The start clears the direction, address and 10-bit flag to 0 and begins a new address phase.
- R3: A rising SDA while SCL is high produces a stop event (code 2) and closes the transfer, so the next start is reported as code 0.
- R4: In the address and data phases, the eighth SCL rising edge produces a byte event (code 3). The byte is built from SDA sampled on each rising edge, most significant bit first.
- R5: The ninth SCL rising edge produces an acknowledge event (code 4) with `evt_nack` equal to SDA at that edge: 0 means acknowledged, 1 means not acknowledged.
- R6: `evt_class` on a byte event is 0 for an address byte of a read, 1 for an address byte of a write, 2 for a data byte of a read and 3 for a data byte of a write.
- R7: The direction (`evt_read`, 1 = read) is taken only from bit 0 of the first address byte after a start. A second address byte never changes it.
- R8: When the first address byte has bits 7:3 equal to 11110, `evt_addr10` is 1 and the next byte is also an address byte. Bits 2:1 of the first byte become `evt_addr[9:8]` and the second byte becomes `evt_addr[7:0]`.
- R9: For any other first address byte, `evt_addr10` is 0 and `evt_addr` is bits 7:1 of that byte, zero-extended.
- R10: For a 7-bit address byte, `evt_byte` is the byte shifted right by one when `cfg_addr_shift` is 1, and the full byte when it is 0. Bytes of a 10-bit address and data bytes are never shifted.
- R11: After the address phase, any number of data bytes may follow, each with its own acknowledge event.
- R12: Every event appears exactly three clock cycles after the line change that causes it.
- R13: SCL pulses while no transfer is open, with SDA held high, produce no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| cfg_addr_shift | input | 1 | 1: report a 7-bit address byte without its direction bit |
| evt_valid | output | 1 | One-cycle strobe marking an event |
| evt_code | output | 3 | 0 start, 1 repeated start, 2 stop, 3 byte, 4 acknowledge |
| evt_byte | output | 8 | Byte value on byte events, 0 otherwise |
| evt_class | output | 2 | Byte class on byte events, 0 otherwise |
| evt_addr | output | 10 | Target address decoded so far in this transfer |
| evt_addr10 | output | 1 | Current address is a 10-bit address |
| evt_read | output | 1 | Transfer direction, 1 = read |
| evt_nack | output | 1 | Acknowledge bit value on acknowledge events, 0 otherwise |

## Verification
Each result follows its causing line change by three clock edges: two synchronizer stages, then the registered event output. The bench records the clock count at the moment it drives each SDA edge for a start or stop, and each SCL rise for the eighth and ninth bits. It then requires the logged event to carry exactly that count plus three. All line changes are spaced at least four cycles apart, so no two events can merge or overlap. The bench compares every field of every logged event against a model entry computed from the bytes it sent.

// File: rtl/i2c_mon_pkg.sv
`timescale 1ns/1ps
package i2c_mon_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;

  typedef enum logic [2:0] {
    EV_START  = 3'd0,
    EV_RSTART = 3'd1,
    EV_STOP   = 3'd2,
    EV_BYTE   = 3'd3,
    EV_ACK    = 3'd4
  } ev_code_t;

  typedef enum logic [1:0] {
    CL_ADDR_RD = 2'd0,
    CL_ADDR_WR = 2'd1,
    CL_DATA_RD = 2'd2,
    CL_DATA_WR = 2'd3
  } byte_class_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_DATA
  } mon_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic lvl,
  output logic lvl_d
);
  // idle bus level is high, so reset to 1 to avoid false edges
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      lvl_d  <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_in};
      lvl_d  <= sync_q[STAGES-1];
    end
  end

  assign lvl = sync_q[STAGES-1];
endmodule

// File: rtl/i2c_frame_decoder.sv
`timescale 1ns/1ps
module i2c_frame_decoder
  import i2c_mon_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl,
  input  logic              scl_prev,
  input  logic              sda_lvl,
  input  logic              sda_prev,
  input  logic              cfg_addr_shift,
  output logic              evt_valid,
  output logic [2:0]        evt_code,
  output logic [BYTE_W-1:0] evt_byte,
  output logic [1:0]        evt_class,
  output logic [ADDR_W-1:0] evt_addr,
  output logic              evt_addr10,
  output logic              evt_read,
  output logic              evt_nack
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [4:0] PFX_10 = 5'b11110;

  mon_state_t        state;
  logic [BYTE_W-2:0] shreg;
  logic [CNT_W-1:0]  bitcnt;
  logic              xfer_open;
  logic              have_first;
  logic              dir_rd;
  logic              addr_is10;
  logic [1:0]        addr_left;
  logic [ADDR_W-1:0] addr_q;

  logic              scl_rise, start_cond, stop_cond;
  logic [BYTE_W-1:0] byte_full;
  logic              pfx_hit, rd_next;
  logic [BYTE_W-1:0] shown;
  logic [1:0]        cls_next;

  always_comb begin
    scl_rise   = scl_lvl & ~scl_prev;
    start_cond = scl_lvl & sda_prev & ~sda_lvl;
    stop_cond  = scl_lvl & ~sda_prev & sda_lvl;
    byte_full  = {shreg, sda_lvl};
    pfx_hit    = (byte_full[BYTE_W-1:BYTE_W-5] == PFX_10);
    rd_next    = have_first ? dir_rd : byte_full[0];
    if (!have_first && !pfx_hit && cfg_addr_shift)
      shown = byte_full >> 1;
    else
      shown = byte_full;
    if (state == ST_ADDR)
      cls_next = rd_next ? CL_ADDR_RD : CL_ADDR_WR;
    else
      cls_next = rd_next ? CL_DATA_RD : CL_DATA_WR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      shreg      <= '0;
      bitcnt     <= '0;
      xfer_open  <= 1'b0;
      have_first <= 1'b0;
      dir_rd     <= 1'b0;
      addr_is10  <= 1'b0;
      addr_left  <= '0;
      addr_q     <= '0;
      evt_valid  <= 1'b0;
      evt_code   <= EV_START;
      evt_byte   <= '0;
      evt_class  <= '0;
      evt_nack   <= 1'b0;
    end else begin
      evt_valid <= 1'b0;
      evt_byte  <= '0;
      evt_class <= '0;
      evt_nack  <= 1'b0;
      if (start_cond) begin
        evt_valid  <= 1'b1;
        evt_code   <= xfer_open ? EV_RSTART : EV_START;
        xfer_open  <= 1'b1;
        state      <= ST_ADDR;
        bitcnt     <= '0;
        have_first <= 1'b0;
        addr_left  <= '0;
        dir_rd     <= 1'b0;
        addr_is10  <= 1'b0;
        addr_q     <= '0;
      end else if (stop_cond) begin
        evt_valid <= 1'b1;
        evt_code  <= EV_STOP;
        xfer_open <= 1'b0;
        state     <= ST_IDLE;
        bitcnt    <= '0;
      end else if (scl_rise) begin
        case (state)
          ST_ADDR, ST_DATA: begin
            shreg <= byte_full[BYTE_W-2:0];
            if (bitcnt == LAST_BIT) begin
              bitcnt    <= '0;
              state     <= ST_ACK;
              evt_valid <= 1'b1;
              evt_code  <= EV_BYTE;
              evt_byte  <= shown;
              evt_class <= cls_next;
              if (state == ST_ADDR) begin
                if (!have_first) begin
                  have_first <= 1'b1;
                  dir_rd     <= byte_full[0];
                  addr_is10  <= pfx_hit;
                  addr_left  <= pfx_hit ? 2'd2 : 2'd1;
                  if (pfx_hit)
                    addr_q <= {byte_full[2:1], {(ADDR_W-2){1'b0}}};
                  else
                    addr_q <= ADDR_W'(byte_full[BYTE_W-1:1]);
                end else begin
                  addr_q[BYTE_W-1:0] <= byte_full;
                end
              end
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
          ST_ACK: begin
            evt_valid <= 1'b1;
            evt_code  <= EV_ACK;
            evt_nack  <= sda_lvl;
            if (addr_left != 2'd0) begin
              addr_left <= addr_left - 2'd1;
              state     <= (addr_left == 2'd1) ? ST_DATA : ST_ADDR;
            end else begin
              state <= ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign evt_addr   = addr_q;
  assign evt_addr10 = addr_is10;
  assign evt_read   = dir_rd;

  // R2
  start_opens_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && (evt_code == EV_START || evt_code == EV_RSTART))
      |-> (state == ST_ADDR && xfer_open && !have_first && bitcnt == '0));

  // R3
  stop_closes_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_code == EV_STOP) |-> (state == ST_IDLE && !xfer_open));

  // R4
  byte_to_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_code == EV_BYTE) |-> (state == ST_ACK && bitcnt == '0));

  // R5
  ack_resumes_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_code == EV_ACK)
      |-> ((state == ST_ADDR || state == ST_DATA) && bitcnt == '0));

  // R7
  dir_held_chk: assert property (@(posedge clk) disable iff (rst)
    (have_first && $past(have_first)) |-> $stable(dir_rd));

  // R9
  short_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !evt_addr10) |-> (evt_addr[ADDR_W-1:BYTE_W-1] == '0));

  // R11
  data_after_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_code == EV_BYTE && evt_class[1]) |-> (addr_left == 2'd0 && have_first));
endmodule

// File: rtl/i2c_bus_monitor.sv
`timescale 1ns/1ps
module i2c_bus_monitor
  import i2c_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_in,
  input  logic        sda_in,
  input  logic        cfg_addr_shift,
  output logic        evt_valid,
  output logic [2:0]  evt_code,
  output logic [7:0]  evt_byte,
  output logic [1:0]  evt_class,
  output logic [9:0]  evt_addr,
  output logic        evt_addr10,
  output logic        evt_read,
  output logic        evt_nack
);
  logic scl_lvl, scl_prev, sda_lvl, sda_prev;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst(rst), .line_in(scl_in), .lvl(scl_lvl), .lvl_d(scl_prev)
  );

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst(rst), .line_in(sda_in), .lvl(sda_lvl), .lvl_d(sda_prev)
  );

  i2c_frame_decoder u_dec (
    .clk(clk), .rst(rst),
    .scl_lvl(scl_lvl), .scl_prev(scl_prev),
    .sda_lvl(sda_lvl), .sda_prev(sda_prev),
    .cfg_addr_shift(cfg_addr_shift),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_byte(evt_byte),
    .evt_class(evt_class), .evt_addr(evt_addr), .evt_addr10(evt_addr10),
    .evt_read(evt_read), .evt_nack(evt_nack)
  );

  // R1
  no_event_in_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> !evt_valid);
endmodule

// File: tb/i2c_bus_monitor_test.sv
`timescale 1ns/1ps
module i2c_bus_monitor_test;
  localparam int H = 4;
  localparam int LAT = 3;
  localparam int MAXE = 32;
  localparam int LIMIT = 190000;

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda = 1'b1, shift = 1'b0;
  logic       evt_valid, evt_addr10, evt_read, evt_nack;
  logic [2:0] evt_code;
  logic [7:0] evt_byte;
  logic [1:0] evt_class;
  logic [9:0] evt_addr;

  i2c_bus_monitor uut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda), .cfg_addr_shift(shift),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_byte(evt_byte),
    .evt_class(evt_class), .evt_addr(evt_addr), .evt_addr10(evt_addr10),
    .evt_read(evt_read), .evt_nack(evt_nack)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0, fails = 0;
  logic [25:0] log_v [MAXE];
  int          log_c [MAXE];
  int          ev_n = 0;
  logic [25:0] exp_v [MAXE];
  int          exp_c [MAXE];
  string       exp_r [MAXE];
  int          exp_n = 0;

  logic       m_open = 1'b0, m_rd = 1'b0, m_a10 = 1'b0;
  logic [9:0] m_addr = '0;
  int         last_edge = 0;

  always @(posedge clk) begin
    #1;
    if (!rst && evt_valid) begin
      if (ev_n < MAXE) begin
        log_v[ev_n] = {evt_code, evt_byte, evt_class, evt_addr, evt_addr10, evt_read, evt_nack};
        log_c[ev_n] = cyc;
      end
      ev_n++;
    end
  end

  always @(posedge clk) begin
    if (cyc == LIMIT) begin
      fails++;
      $display("FAIL watchdog R12: got cycle %0d expected end before %0d", cyc, LIMIT);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [25:0] mk(logic [2:0] c, logic [7:0] b, logic [1:0] cl, logic nk);
    return {c, b, cl, m_addr, m_a10, m_rd, nk};
  endfunction

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(logic [25:0] v, string r);
    exp_v[exp_n] = v;
    exp_r[exp_n] = r;
    exp_c[exp_n] = last_edge + LAT;
    exp_n++;
  endtask

  task automatic put_bit(logic b);
    sda = b; wt(H);
    scl = 1'b1; last_edge = cyc; wt(2*H);
    scl = 1'b0; wt(H);
  endtask

  task automatic do_start();
    if (m_open) begin
      sda = 1'b1; wt(H);
      scl = 1'b1; wt(2*H);
    end
    sda = 1'b0; last_edge = cyc;
    m_addr = '0; m_a10 = 1'b0; m_rd = 1'b0;
    push(mk(m_open ? 3'd1 : 3'd0, 8'h00, 2'd0, 1'b0), "R2");
    m_open = 1'b1;
    wt(2*H);
    scl = 1'b0; wt(H);
  endtask

  task automatic do_stop();
    sda = 1'b0; wt(H);
    scl = 1'b1; wt(2*H);
    sda = 1'b1; last_edge = cyc;
    push(mk(3'd2, 8'h00, 2'd0, 1'b0), "R3");
    m_open = 1'b0;
    wt(2*H);
  endtask

  task automatic put_byte(logic [7:0] b, logic [7:0] shown, logic [1:0] cl, logic nk, string r);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    push(mk(3'd3, shown, cl, 1'b0), r);
    put_bit(nk);
    push(mk(3'd4, 8'h00, 2'd0, nk), "R5");
  endtask

  task automatic addr7(logic [6:0] a, logic rd);
    m_rd = rd; m_a10 = 1'b0; m_addr = {3'b000, a};
    put_byte({a, rd}, shift ? {1'b0, a} : {a, rd}, rd ? 2'd0 : 2'd1, 1'b0, "R9 R6 R7 R10");
  endtask

  task automatic addr10(logic [9:0] a, logic rd);
    m_rd = rd; m_a10 = 1'b1; m_addr = {a[9:8], 8'h00};
    put_byte({5'b11110, a[9:8], rd}, {5'b11110, a[9:8], rd}, rd ? 2'd0 : 2'd1, 1'b0, "R8 R10");
    m_addr = a;
    put_byte(a[7:0], a[7:0], rd ? 2'd0 : 2'd1, 1'b0, "R8 R7");
  endtask

  task automatic data(logic [7:0] d, logic nk);
    put_byte(d, d, m_rd ? 2'd2 : 2'd3, nk, "R4 R6 R11");
  endtask

  task automatic verify();
    wt(8);
    for (int i = 0; i < exp_n; i++) begin
      tests++;
      if (i >= ev_n) begin
        fails++;
        $display("FAIL %s event %0d missing: got none expected %h", exp_r[i], i, exp_v[i]);
      end else if (log_v[i] !== exp_v[i]) begin
        fails++;
        $display("FAIL %s event %0d: got %h expected %h", exp_r[i], i, log_v[i], exp_v[i]);
      end
      if (i < ev_n) begin
        tests++;
        if (log_c[i] != exp_c[i]) begin
          fails++;
          $display("FAIL R12 event %0d latency: got cycle %0d expected %0d", i, log_c[i], exp_c[i]);
        end
      end
    end
    tests++;
    if (ev_n != exp_n) begin
      fails++;
      $display("FAIL R13 event count: got %0d expected %0d", ev_n, exp_n);
    end
    ev_n = 0;
    exp_n = 0;
  endtask

  initial begin
    wt(5);
    rst = 1'b0;
    wt(10);
    tests++;
    if (ev_n != 0 || evt_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: got %0d events expected 0", ev_n);
    end

    // R13: SCL pulses on an idle bus
    repeat (4) begin
      scl = 1'b0; wt(H);
      scl = 1'b1; wt(H);
    end
    wt(8);
    tests++;
    if (ev_n != 0) begin
      fails++;
      $display("FAIL R13 idle clocks: got %0d events expected 0", ev_n);
    end

    // 7-bit sweep over addresses, direction and shift mode
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 128; a += 5) begin
        for (int rd = 0; rd < 2; rd++) begin
          if (a[6:2] == 5'b11110) continue;
          shift = s[0];
          do_start();
          addr7(a[6:0], rd[0]);
          data(8'(a * 3 + rd), rd[0]);
          do_stop();
          verify();
        end
      end
    end

    // 10-bit sweep, shift input toggled to show it has no effect
    for (int a = 0; a < 1024; a += 37) begin
      for (int rd = 0; rd < 2; rd++) begin
        shift = a[0];
        do_start();
        addr10(a[9:0], rd[0]);
        data(a[7:0] ^ 8'h5A, 1'b0);
        do_stop();
        verify();
      end
    end
    shift = 1'b1;
    do_start(); addr10(10'h3FF, 1'b0); data(8'hC3, 1'b1); do_stop(); verify();

    // R2 repeated start: write then read to the same target
    shift = 1'b0;
    do_start();
    addr7(7'h50, 1'b0);
    data(8'h12, 1'b0);
    do_start();
    addr7(7'h50, 1'b1);
    data(8'hA5, 1'b0);
    data(8'h3C, 1'b1);
    do_stop();
    verify();

    // R2 repeated start after a 10-bit write
    do_start();
    addr10(10'h2C5, 1'b0);
    data(8'h81, 1'b0);
    do_start();
    addr7(7'h11, 1'b1);
    data(8'h7E, 1'b1);
    do_stop();
    verify();

    // R11 long data run
    do_start();
    addr7(7'h21, 1'b0);
    for (int k = 0; k < 6; k++) data(8'(8'h10 + k * 29), k == 5);
    do_stop();
    verify();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule